// File: doc/BRIEF.md
# Masked-Access GPIO Port Controller

This block controls an 8-pin general-purpose I/O port through a simple 32-bit register bus. The bus has a valid strobe, a write enable, a byte address and write data. For each pin there is a register that sets its direction and one that connects it digitally. The pad side uses separate input, output and output-enable vectors, so the block sits between a bus decoder and the pad ring.

The port value is reached through a 1 KiB address window. The word-address bits [9:2] act as a per-pin mask, so software can set or sample any subset of pins in one access with no read-modify-write. Each pin also has an interrupt detector. It can sense an edge or a level, one edge or both edges, and high or low polarity. Edge events latch into a raw status that software clears by writing ones. A pending view is the raw status gated by a per-pin enable, and the single interrupt output is the OR of that view.

Register map by byte offset:

| Offset | Name | Meaning |
|---|---|---|
| 0x000–0x3FC | VAL | port value, accessed through the address mask |
| 0x400 | DRV | direction, 1 = output |
| 0x404 | TRG | sense, 1 = level, 0 = edge |
| 0x408 | DUAL | 1 = both edges in edge mode |
| 0x40C | POL | polarity |
| 0x410 | ENA | interrupt enable |
| 0x414 | RAW | raw status, read-only |
| 0x418 | PEND | pending status, read-only |
| 0x41C | ACK | write-one-to-clear |
| 0x51C | CONN | digital connect |

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register and the outputs `gpio_o`, `gpio_oe_o`, `irq_o` and `bus_rdata_o` are 0.
- R2: A write anywhere in the 0x000–0x3FC window updates output bit i only where address bit (i+2) is 1. The new value comes from write data bit i, and all other output bits hold.
- R3: A read in the VAL window returns 0 for every pin whose address mask bit is 0. For an unmasked connected pin, the read returns the output register bit when DRV is 1 and the synchronized pin input when DRV is 0.
- R4: `gpio_o` always shows the output register, and `gpio_oe_o` bit i is DRV[i] AND CONN[i].
- R5: A pin with CONN[i]=0 reads 0 in VAL, drives no output enable, and never sets RAW[i].
- R6: In edge mode (TRG=0, DUAL=0), POL=1 latches RAW on a rising input and POL=0 latches it on a falling input.
- R7: In edge mode with DUAL=1, both edges latch RAW whatever the POL value.
- R8: In level mode (TRG=1), RAW[i] is 1 while the connected pin equals POL[i]. This status is not latched, and ACK does not clear it.
- R9: Writing ACK clears the latched edge status bits written as 1 and leaves bits written as 0 unchanged. An edge event in the same cycle as its clear keeps the bit set.
- R10: PEND reads RAW AND ENA, and `irq_o` is the OR of PEND.
- R11: DRV, TRG, DUAL, POL, ENA and CONN read back what was written. Writes to RAW and PEND have no effect, and reads of unmapped addresses return 0.
- R12: Read data appears on `bus_rdata_o` at the clock edge that accepts the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| bus_valid_i | input | 1 | bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | byte address |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | registered read data |
| gpio_i | input | 8 | pin inputs |
| gpio_o | output | 8 | pin output values |
| gpio_oe_o | output | 8 | pin output enables |
| irq_o | output | 1 | combined interrupt |

## Verification
Two things can land on the same clock edge: an edge event reaching the status latch and a software ACK clearing that same bit. The bench raises a pin, waits exactly two edges while the synchronizer fills, and then issues the ACK write so the clear and the event meet on the third edge. The bit must read back as set, and a second ACK must then clear it. Random rounds also pair ACK writes of random values with fresh edge activity, and every round's status is compared against a bench model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [11:0] OFF_DRV  = 12'h400;
  localparam logic [11:0] OFF_TRG  = 12'h404;
  localparam logic [11:0] OFF_DUAL = 12'h408;
  localparam logic [11:0] OFF_POL  = 12'h40C;
  localparam logic [11:0] OFF_ENA  = 12'h410;
  localparam logic [11:0] OFF_RAW  = 12'h414;
  localparam logic [11:0] OFF_PEND = 12'h418;
  localparam logic [11:0] OFF_ACK  = 12'h41C;
  localparam logic [11:0] OFF_CONN = 12'h51C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] conn_i,
  input  logic [NPINS-1:0] level_i,
  input  logic [NPINS-1:0] dual_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] ack_i,
  output logic [NPINS-1:0] raw_o
);
  // prev tracks the unqualified pin so connecting a high pin makes no edge
  logic [NPINS-1:0] prev_q, lat_q, lat_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= pin_i;
      lat_q  <= lat_d;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, hit, ev, lvl;
    assign rise = pin_i[i] & ~prev_q[i];
    assign fall = ~pin_i[i] & prev_q[i];
    assign hit  = dual_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
    assign ev   = conn_i[i] & ~level_i[i] & hit;
    // event has priority over a clear in the same cycle
    assign lat_d[i] = ev | (lat_q[i] & ~ack_i[i]);
    assign lvl      = conn_i[i] & (pol_i[i] ? pin_i[i] : ~pin_i[i]);
    assign raw_o[i] = level_i[i] ? lvl : lat_q[i];
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NPINS-1:0]  gpio_i,
  output logic [NPINS-1:0]  gpio_o,
  output logic [NPINS-1:0]  gpio_oe_o,
  output logic              irq_o
);
  localparam int MLO = 2;
  localparam int MHI = MLO + NPINS - 1;

  logic [NPINS-1:0] out_q, drv_q, trg_q, dual_q, pol_q, ena_q, conn_q;
  logic [NPINS-1:0] pin_s, raw, pend, mask, wd, ack, val_rd;
  logic [31:0]      rd_val, rdata_q;
  logic             wr, rd, in_win;
  logic             s_drv, s_trg, s_dual, s_pol, s_ena, s_raw, s_pend, s_ack, s_conn;

  assign wr     = bus_valid_i & bus_we_i;
  assign rd     = bus_valid_i & ~bus_we_i;
  assign in_win = (bus_addr_i[ADDR_W-1:MHI+1] == '0);
  assign mask   = bus_addr_i[MHI:MLO];
  assign wd     = bus_wdata_i[NPINS-1:0];

  assign s_drv  = bus_addr_i == ADDR_W'(OFF_DRV);
  assign s_trg  = bus_addr_i == ADDR_W'(OFF_TRG);
  assign s_dual = bus_addr_i == ADDR_W'(OFF_DUAL);
  assign s_pol  = bus_addr_i == ADDR_W'(OFF_POL);
  assign s_ena  = bus_addr_i == ADDR_W'(OFF_ENA);
  assign s_raw  = bus_addr_i == ADDR_W'(OFF_RAW);
  assign s_pend = bus_addr_i == ADDR_W'(OFF_PEND);
  assign s_ack  = bus_addr_i == ADDR_W'(OFF_ACK);
  assign s_conn = bus_addr_i == ADDR_W'(OFF_CONN);

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      drv_q  <= '0;
      trg_q  <= '0;
      dual_q <= '0;
      pol_q  <= '0;
      ena_q  <= '0;
      conn_q <= '0;
    end else if (wr) begin
      if (in_win) out_q  <= (out_q & ~mask) | (wd & mask);
      if (s_drv)  drv_q  <= wd;
      if (s_trg)  trg_q  <= wd;
      if (s_dual) dual_q <= wd;
      if (s_pol)  pol_q  <= wd;
      if (s_ena)  ena_q  <= wd;
      if (s_conn) conn_q <= wd;
    end
  end

  assign ack = (wr && s_ack) ? wd : '0;

  gpio_irq_unit #(.NPINS(NPINS)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_s),
    .conn_i (conn_q),
    .level_i(trg_q),
    .dual_i (dual_q),
    .pol_i  (pol_q),
    .ack_i  (ack),
    .raw_o  (raw)
  );

  assign pend   = raw & ena_q;
  assign val_rd = ((drv_q & out_q) | (~drv_q & pin_s)) & conn_q & mask;

  always_comb begin
    rd_val = '0;
    if      (in_win) rd_val[NPINS-1:0] = val_rd;
    else if (s_drv)  rd_val[NPINS-1:0] = drv_q;
    else if (s_trg)  rd_val[NPINS-1:0] = trg_q;
    else if (s_dual) rd_val[NPINS-1:0] = dual_q;
    else if (s_pol)  rd_val[NPINS-1:0] = pol_q;
    else if (s_ena)  rd_val[NPINS-1:0] = ena_q;
    else if (s_raw)  rd_val[NPINS-1:0] = raw;
    else if (s_pend) rd_val[NPINS-1:0] = pend;
    else if (s_conn) rd_val[NPINS-1:0] = conn_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign bus_rdata_o = rdata_q;
  assign gpio_o      = out_q;
  assign gpio_oe_o   = drv_q & conn_q;
  assign irq_o       = |pend;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic [NPINS-1:0]  gpio_o,
  input logic [NPINS-1:0]  gpio_oe_o,
  input logic              irq_o
);
  localparam int MHI = NPINS + 1;

  logic             win;
  logic [NPINS-1:0] msk, wdn;
  assign win = bus_addr_i[ADDR_W-1:MHI+1] == '0;
  assign msk = bus_addr_i[MHI:2];
  assign wdn = bus_wdata_i[NPINS-1:0];

  // R2
  masked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_we_i && win) |=>
      gpio_o == (($past(gpio_o) & ~$past(msk)) | ($past(wdn) & $past(msk))));

  // R2
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && bus_we_i && win) |=> $stable(gpio_o));

  // R3
  read_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_we_i && win) |=> (bus_rdata_o[NPINS-1:0] & ~$past(msk)) == '0);

  // R5
  disconnect_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_we_i && bus_addr_i == ADDR_W'(OFF_CONN) && wdn == '0) |=> gpio_oe_o == '0);

  // R10
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_we_i && bus_addr_i == ADDR_W'(OFF_ENA) && wdn == '0) |=> !irq_o);

  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && !bus_we_i) |=> $stable(bus_rdata_o));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_valid_i(bus_valid_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .gpio_o     (gpio_o),
  .gpio_oe_o  (gpio_oe_o),
  .irq_o      (irq_o)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pins = '0;
  logic [7:0]  gout, goe;
  logic        irq;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_out, m_drv, m_trg, m_dual, m_pol, m_ena, m_conn, m_lat;

  always #4 clk = ~clk;

  gpio_port_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .gpio_i(pins), .gpio_o(gout), .gpio_oe_o(goe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and end right after a falling edge
  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] d);
    valid = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask

  function automatic logic [7:0] exp_raw();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = m_trg[i] ? (m_conn[i] & (m_pol[i] ? pins[i] : ~pins[i])) : m_lat[i];
    return r;
  endfunction

  function automatic logic [7:0] exp_val(input logic [7:0] msk);
    return ((m_drv & m_out) | (~m_drv & pins)) & m_conn & msk;
  endfunction

  function automatic logic [7:0] edge_ev(input logic [7:0] o, input logic [7:0] n);
    logic [7:0] e;
    for (int i = 0; i < 8; i++) begin
      logic r, f;
      r = n[i] & ~o[i];
      f = ~n[i] & o[i];
      e[i] = m_conn[i] & ~m_trg[i] & (m_dual[i] ? (r | f) : (m_pol[i] ? r : f));
    end
    return e;
  endfunction

  task automatic set_pins(input logic [7:0] v);
    m_lat = m_lat | edge_ev(pins, v);
    pins = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] drv, input logic [7:0] trg, input logic [7:0] dual,
                     input logic [7:0] pol, input logic [7:0] ena, input logic [7:0] conn);
    bwr(12'h400, {24'h0, drv});  m_drv  = drv;
    bwr(12'h404, {24'h0, trg});  m_trg  = trg;
    bwr(12'h408, {24'h0, dual}); m_dual = dual;
    bwr(12'h40C, {24'h0, pol});  m_pol  = pol;
    bwr(12'h410, {24'h0, ena});  m_ena  = ena;
    bwr(12'h51C, {24'h0, conn}); m_conn = conn;
  endtask

  task automatic check_irq(input string req);
    logic [31:0] d;
    logic [7:0]  r;
    r = exp_raw();
    brd(12'h414, d); chk({req, " raw"}, d, {24'h0, r});
    brd(12'h418, d); chk("R10 pend", d, {24'h0, r & m_ena});
    chk("R10 irq", {31'h0, irq}, {31'h0, |(r & m_ena)});
  endtask

  task automatic ack(input logic [7:0] v);
    bwr(12'h41C, {24'h0, v});
    m_lat = m_lat & ~v;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_0001));
    m_out = '0; m_drv = '0; m_trg = '0; m_dual = '0; m_pol = '0; m_ena = '0; m_conn = '0; m_lat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 gpio_o", {24'h0, gout}, 32'h0);
    chk("R1 oe", {24'h0, goe}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    brd(12'h410, d); chk("R1 ena", d, 32'h0);
    brd(12'h51C, d); chk("R1 conn", d, 32'h0);

    // R2 masked write: mask 0x0F via addr 0x03C
    bwr(12'h03C, 32'hFF); m_out = 8'h0F;
    chk("R2 low nibble", {24'h0, gout}, 32'h0F);
    bwr(12'h300, 32'h00); m_out = 8'h0F;
    chk("R2 masked-out hold", {24'h0, gout}, 32'h0F);
    bwr(12'h200, 32'hFF); m_out = 8'h8F;
    chk("R2 single bit", {24'h0, gout}, 32'h8F);

    // R4 oe and R3 readback
    cfg(8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hCC);
    chk("R4 oe", {24'h0, goe}, 32'hC0);
    set_pins(8'hA5);
    brd(12'h3FC, d); chk("R3 full mask", d, {24'h0, exp_val(8'hFF)});
    brd(12'h0C0, d); chk("R3 partial mask", d, {24'h0, exp_val(8'h30)});
    // R5 disconnected input reads 0
    brd(12'h00C, d); chk("R5 disconnected read", d, {24'h0, exp_val(8'h03)});

    // R11 readback, ignored writes, unmapped
    brd(12'h400, d); chk("R11 drv", d, 32'hF0);
    brd(12'h51C, d); chk("R11 conn", d, 32'hCC);
    brd(12'h500, d); chk("R11 unmapped", d, 32'h0);
    bwr(12'h414, 32'hFF); bwr(12'h418, 32'hFF);
    check_irq("R11 ro write");

    // R12 latency and hold
    valid = 1'b1; we = 1'b0; addr = 12'h400;
    @(negedge clk); valid = 1'b0; addr = 12'h404;
    chk("R12 one-cycle read", rdata, 32'hF0);
    @(negedge clk);
    chk("R12 hold", rdata, 32'hF0);

    // R6 rising and falling, single edge
    cfg(8'h00, 8'h00, 8'h00, 8'h0F, 8'hFF, 8'hFF);
    set_pins(8'h00); ack(8'hFF);
    set_pins(8'hFF); check_irq("R6 rise");
    set_pins(8'h00); check_irq("R6 fall");
    ack(8'h0F); check_irq("R9 partial ack");
    ack(8'hFF);

    // R7 both edges ignore polarity
    cfg(8'h00, 8'h00, 8'hFF, 8'h55, 8'hFF, 8'hFF);
    set_pins(8'h3C); check_irq("R7 both");
    ack(8'hFF); set_pins(8'h00); check_irq("R7 both fall");
    ack(8'hFF);

    // R8 level, not cleared by ack
    cfg(8'h00, 8'hFF, 8'h00, 8'h0F, 8'hFF, 8'hFF);
    set_pins(8'h33); check_irq("R8 level");
    ack(8'hFF); check_irq("R8 ack no effect");

    // R5 no interrupt when disconnected (edge and level)
    cfg(8'h00, 8'h0F, 8'hF0, 8'h00, 8'hFF, 8'h00);
    set_pins(8'hCC); check_irq("R5 disconnected irq");
    set_pins(8'h00); check_irq("R5 disconnected irq low");

    // R9 event and clear on the same edge
    cfg(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01);
    ack(8'hFF);
    pins = 8'h01;
    @(negedge clk); @(negedge clk);
    bwr(12'h41C, 32'h01);
    m_lat = 8'h01;
    repeat (3) @(negedge clk);
    check_irq("R9 set wins");
    ack(8'h01); check_irq("R9 clear after");

    // random rounds
    for (int it = 0; it < 60; it++) begin
      logic [7:0] mk, v;
      cfg(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      mk = 8'($urandom); v = 8'($urandom);
      bwr({2'b00, mk, 2'b00}, {24'h0, v});
      m_out = (m_out & ~mk) | (v & mk);
      chk("R2 random", {24'h0, gout}, {24'h0, m_out});
      chk("R4 random", {24'h0, goe}, {24'h0, m_drv & m_conn});
      set_pins(8'($urandom));
      mk = 8'($urandom);
      brd({2'b00, mk, 2'b00}, d); chk("R3 random", d, {24'h0, exp_val(mk)});
      check_irq("R6 random");
      ack(8'($urandom));
      check_irq("R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule